// File: doc/BRIEF.md
# Isochronous Cycle Master Timer

This block paces the isochronous cycles of a serial bus when the local node is the root of the bus tree. A free-running tick counter, clocked at 24.576 MHz by default, marks a nominal cycle boundary every 3072 ticks (125 µs). The cycle counter advances at each boundary. At a boundary the block arms a pending cycle start. It issues that start only when the bus is sampled idle, and reports with the start how many ticks it was held back.

The block also keeps a per-cycle tally of ticks during which isochronous traffic occupies the bus. If that tally exceeds the limit (100 µs worth of ticks by default), the bus is treated as over-allocated and the block stops issuing cycle starts. The stop persists until a bus reset or a software enable pulse. After either one, starts resume at the next boundary as long as the node is still root. Framing and transmitting the start packet are left to the logic that consumes the start request.

Top module: `cycle_master_timer`

## Requirements
- R1: While reset is asserted and right after it, `startReq` is 0, `startDelay` is 0 and `cycleCount` is 0.
- R2: A boundary occurs once every `CYCLE_TICKS` clocks. `cycleCount` increases by exactly 1 at each boundary, wraps modulo 2^`COUNT_W`, and is unaffected by root status, bus activity, stop state or bus reset.
- R3: When `isRoot` is sampled low, `startReq` is 0 in the next cycle. Dropping root status also cancels a start that is still pending.
- R4: As root, with the bus idle and no stop, `startReq` pulses high for one cycle, one clock after each boundary edge, with `startDelay` = 0.
- R5: When the bus is busy at the boundary, the start waits for the first clock at which `busIdle` is sampled high. `startDelay` then equals the number of clocks after the boundary at which `busIdle` was sampled low.
- R6: `startDelay` saturates at 2^`DELAY_W`-1 and does not wrap.
- R7: At most one start is issued per cycle. If a boundary arrives while a start is still pending, the old start is dropped, and the delay of the new start is counted from the new boundary.
- R8: As root, when `isoActive` is sampled high on more than `ISO_LIMIT` clocks within one cycle, no further starts are issued. Exactly `ISO_LIMIT` active clocks does not stop the block.
- R9: The over-allocation stop is sticky. A one-clock pulse on `swEnable` or `busReset` clears it, and starts resume from the following boundary.
- R10: A `busReset` pulse cancels a pending start, clears the per-cycle isochronous tally, and produces no start in the cycle after it.
- R11: `startDelay` holds its value between starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rstN | input | 1 | Asynchronous active-low reset |
| isRoot | input | 1 | Node currently holds the root role |
| busIdle | input | 1 | Bus carries no packet this tick |
| isoActive | input | 1 | Isochronous traffic occupies the bus this tick |
| busReset | input | 1 | One-clock pulse at each bus reset |
| swEnable | input | 1 | One-clock pulse that re-enables after an over-allocation stop |
| startReq | output | 1 | One-clock cycle-start request |
| startDelay | output | DELAY_W | Ticks the latest start was held past its boundary |
| cycleCount | output | COUNT_W | Nominal cycle number |

## Verification
On every cycle, the assertions check the following: the start is a single-clock pulse, it is never issued without an idle sample or after a non-root or bus-reset sample, the delay field holds between starts, and the cycle counter only steps by one. The other behaviours depend on counting clocks over whole cycles, so only the bench's scenarios can show them: the exact delay value, saturation, replacement of a stale pending start, the over-allocation threshold with its exact boundary, and the sticky stop with its two ways of release. For these, the bench's reference model counts ticks and tallies independently.

// File: rtl/cm_pkg.sv
package cm_pkg;
  // Strobes from the control FSM into the datapath
  typedef struct packed {
    logic captureDelay;  // copy running delay into startDelay
    logic clearIso;      // drop the per-cycle isochronous tally
  } cmStrobe_t;
endpackage

// File: rtl/cm_datapath.sv
module cm_datapath
  import cm_pkg::*;
#(
  parameter int CYCLE_TICKS = 3072,
  parameter int ISO_LIMIT   = 2458,
  parameter int DELAY_W     = 12,
  parameter int COUNT_W     = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               isoActive,
  input  cmStrobe_t          strobe,
  output logic               boundary,
  output logic               isoOver,
  output logic [DELAY_W-1:0] startDelay,
  output logic [COUNT_W-1:0] cycleCount
);
  localparam int TICK_W = $clog2(CYCLE_TICKS);
  localparam int ISO_W  = $clog2(ISO_LIMIT + 1);
  localparam logic [TICK_W-1:0]  LAST_TICK = TICK_W'(CYCLE_TICKS - 1);
  localparam logic [ISO_W-1:0]   ISO_CAP   = ISO_W'(ISO_LIMIT);
  localparam logic [DELAY_W-1:0] DELAY_MAX = '1;

  logic [TICK_W-1:0]  tickCnt;
  logic [DELAY_W-1:0] delayCnt;
  logic [ISO_W-1:0]   isoCnt;

  assign boundary = (tickCnt == LAST_TICK);
  assign isoOver  = isoActive && (isoCnt >= ISO_CAP);

  // Free-running nominal timer and cycle number
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt    <= '0;
      cycleCount <= '0;
    end else if (boundary) begin
      tickCnt    <= '0;
      cycleCount <= cycleCount + COUNT_W'(1);
    end else begin
      tickCnt <= tickCnt + TICK_W'(1);
    end
  end

  // Ticks since the last boundary, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     delayCnt <= '0;
    else if (boundary)             delayCnt <= '0;
    else if (delayCnt != DELAY_MAX) delayCnt <= delayCnt + DELAY_W'(1);
  end

  // Per-cycle isochronous occupancy tally, saturating at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             isoCnt <= '0;
    else if (boundary || strobe.clearIso)  isoCnt <= '0;
    else if (isoActive && isoCnt != ISO_CAP) isoCnt <= isoCnt + ISO_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   startDelay <= '0;
    else if (strobe.captureDelay) startDelay <= delayCnt;
  end
endmodule

// File: rtl/cm_control.sv
module cm_control
  import cm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      isRoot,
  input  logic      busIdle,
  input  logic      busReset,
  input  logic      swEnable,
  input  logic      boundary,
  input  logic      isoOver,
  output cmStrobe_t strobe,
  output logic      startReq
);
  logic pending;
  logic stopped;
  logic fire;

  assign fire = pending && busIdle && !boundary && isRoot && !busReset && !stopped;

  always_comb begin
    strobe              = '0;
    strobe.captureDelay = fire;
    strobe.clearIso     = busReset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              pending <= 1'b0;
    else if (busReset || !isRoot || stopped) pending <= 1'b0;
    else if (boundary)                      pending <= 1'b1;
    else if (fire)                          pending <= 1'b0;
  end

  // Over-allocation stop: sticky until bus reset or software enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    stopped <= 1'b0;
    else if (busReset || swEnable) stopped <= 1'b0;
    else if (isRoot && isoOver)   stopped <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startReq <= 1'b0;
    else       startReq <= fire;
  end
endmodule

// File: rtl/cycle_master_timer.sv
module cycle_master_timer
  import cm_pkg::*;
#(
  parameter int CYCLE_TICKS = 3072,
  parameter int ISO_LIMIT   = 2458,
  parameter int DELAY_W     = 12,
  parameter int COUNT_W     = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               isRoot,
  input  logic               busIdle,
  input  logic               isoActive,
  input  logic               busReset,
  input  logic               swEnable,
  output logic               startReq,
  output logic [DELAY_W-1:0] startDelay,
  output logic [COUNT_W-1:0] cycleCount
);
  cmStrobe_t strobe;
  logic boundary;
  logic isoOver;

  cm_control u_ctl (
    .clk(clk), .rstN(rstN), .isRoot(isRoot), .busIdle(busIdle),
    .busReset(busReset), .swEnable(swEnable), .boundary(boundary),
    .isoOver(isoOver), .strobe(strobe), .startReq(startReq)
  );

  cm_datapath #(
    .CYCLE_TICKS(CYCLE_TICKS), .ISO_LIMIT(ISO_LIMIT),
    .DELAY_W(DELAY_W), .COUNT_W(COUNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .isoActive(isoActive), .strobe(strobe),
    .boundary(boundary), .isoOver(isoOver),
    .startDelay(startDelay), .cycleCount(cycleCount)
  );
endmodule

// File: rtl/cm_checker.sv
module cm_checker #(
  parameter int DELAY_W = 12,
  parameter int COUNT_W = 13
) (
  input logic               clk,
  input logic               rstN,
  input logic               isRoot,
  input logic               busIdle,
  input logic               busReset,
  input logic               startReq,
  input logic [DELAY_W-1:0] startDelay,
  input logic [COUNT_W-1:0] cycleCount
);
  AST_START_IS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> !startReq); // R7
  AST_NONROOT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !isRoot |=> !startReq); // R3
  AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    startReq |-> $past(busIdle)); // R5
  AST_BUSRESET_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> !startReq); // R10
  AST_DELAY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !startReq |-> $stable(startDelay)); // R11
  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cycleCount) |-> cycleCount == $past(cycleCount) + COUNT_W'(1)); // R2
endmodule

bind cycle_master_timer cm_checker #(.DELAY_W(DELAY_W), .COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .isRoot(isRoot), .busIdle(busIdle), .busReset(busReset),
  .startReq(startReq), .startDelay(startDelay), .cycleCount(cycleCount)
);

// File: tb/tb_cycle_master_timer.sv
`timescale 1ns/1ps
module tb_cycle_master_timer;
  localparam int CT = 64, IL = 40, DW = 5, CW = 4;
  localparam int DMAX = (1 << DW) - 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic isRoot = 1'b0, busIdle = 1'b1, isoActive = 1'b0, busReset = 1'b0, swEnable = 1'b0;
  logic startReq;
  logic [DW-1:0] startDelay;
  logic [CW-1:0] cycleCount;

  always #2 clk = ~clk;

  cycle_master_timer #(.CYCLE_TICKS(CT), .ISO_LIMIT(IL), .DELAY_W(DW), .COUNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .isRoot(isRoot), .busIdle(busIdle), .isoActive(isoActive),
    .busReset(busReset), .swEnable(swEnable), .startReq(startReq),
    .startDelay(startDelay), .cycleCount(cycleCount));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: ticks, pending start, tally, stop flag
  int mTick = 0, mCount = 0, mDelay = 0, mIso = 0, mStartDelay = 0;
  bit mPending = 0, mStopped = 0, mReq = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      mTick = 0; mCount = 0; mDelay = 0; mIso = 0; mStartDelay = 0;
      mPending = 0; mStopped = 0; mReq = 0;
    end else begin
      bit atEdge, go, over;
      atEdge = (mTick == CT - 1);
      over   = isoActive && (mIso >= IL);
      go     = mPending && busIdle && !atEdge && isRoot && !busReset && !mStopped;
      mReq = go;
      if (go) mStartDelay = mDelay;
      if (busReset || !isRoot || mStopped) mPending = 0;
      else if (atEdge) mPending = 1;
      else if (go) mPending = 0;
      if (busReset || swEnable) mStopped = 0;
      else if (isRoot && over) mStopped = 1;
      if (atEdge || busReset) mIso = 0;
      else if (isoActive && mIso < IL) mIso++;
      if (atEdge) mDelay = 0;
      else if (mDelay < DMAX) mDelay++;
      if (atEdge) begin mTick = 0; mCount = (mCount + 1) % (1 << CW); end
      else mTick++;
    end
  end

  // Per-clock comparison against the reference
  always @(negedge clk) if (!done) begin
    check(startReq === mReq, "R4 R5 R8 startReq vs model", int'(startReq), int'(mReq));
    check(startDelay === DW'(mStartDelay), "R5 R6 R11 startDelay vs model", int'(startDelay), mStartDelay);
    check(cycleCount === CW'(mCount), "R2 cycleCount vs model", int'(cycleCount), mCount);
  end

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic countStarts(int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); if (startReq) c++; end
  endtask
  task automatic alignToStart();
    do @(negedge clk); while (!startReq);
  endtask
  task automatic delayedStart(int k, string tag, int expDelay);
    int c;
    alignToStart();
    busIdle = 1'b0;
    countStarts(CT - 1 + k, c);
    check(c == 0, {tag, " no start while busy"}, c, 0);
    busIdle = 1'b1;
    @(negedge clk);
    check(startReq == 1'b1, {tag, " start after idle"}, int'(startReq), 1);
    check(int'(startDelay) == expDelay, {tag, " delay value"}, int'(startDelay), expDelay);
  endtask

  initial begin
    int c, cc;
    waitN(3);
    check(startReq == 0 && startDelay == 0 && cycleCount == 0, "R1 reset state",
          int'(startReq) + int'(startDelay) + int'(cycleCount), 0);
    rstN = 1'b1;
    // R3: not root, no starts
    countStarts(3 * CT, c);
    check(c == 0, "R3 non-root starts", c, 0);
    // R4: root, idle bus
    isRoot = 1'b1;
    waitN(CT);
    countStarts(4 * CT, c);
    check(c == 4, "R4 one start per cycle", c, 4);
    alignToStart();
    check(startDelay == 0, "R4 idle delay zero", int'(startDelay), 0);
    // R2: one boundary per CT clocks
    cc = int'(cycleCount);
    waitN(CT);
    check(int'(cycleCount) == (cc + 1) % 16, "R2 count step", int'(cycleCount), (cc + 1) % 16);
    // R5 / R6 / R7
    delayedStart(7, "R5", 7);
    delayedStart(40, "R6", DMAX);
    delayedStart(CT + 5, "R7", 5);
    // R3: losing root cancels pending
    alignToStart();
    busIdle = 1'b0; waitN(CT + 2); isRoot = 1'b0; busIdle = 1'b1;
    countStarts(CT, c);
    check(c == 0, "R3 drop root cancels", c, 0);
    isRoot = 1'b1; waitN(CT);
    // R10: bus reset cancels pending
    alignToStart();
    busIdle = 1'b0; waitN(CT + 2); busReset = 1'b1; waitN(1); busReset = 1'b0; busIdle = 1'b1;
    countStarts(CT - 10, c);
    check(c == 0, "R10 bus reset cancels pending", c, 0);
    // R8: exactly ISO_LIMIT active clocks keeps running
    alignToStart();
    isoActive = 1'b1; waitN(IL); isoActive = 1'b0;
    countStarts(3 * CT, c);
    check(c == 3, "R8 limit not exceeded", c, 3);
    // R8: exceed limit stops
    alignToStart();
    isoActive = 1'b1; waitN(IL + 5); isoActive = 1'b0;
    countStarts(3 * CT, c);
    check(c == 0, "R8 over-allocation stops", c, 0);
    // R9: sticky, released by swEnable
    countStarts(2 * CT, c);
    check(c == 0, "R9 stop is sticky", c, 0);
    swEnable = 1'b1; waitN(1); swEnable = 1'b0;
    waitN(CT);
    countStarts(2 * CT, c);
    check(c == 2, "R9 swEnable resumes", c, 2);
    // R9 / R10: released by bus reset
    alignToStart();
    isoActive = 1'b1; waitN(IL + 5); isoActive = 1'b0;
    countStarts(CT, c);
    check(c == 0, "R9 stopped again", c, 0);
    busReset = 1'b1; waitN(1); busReset = 1'b0;
    waitN(CT);
    countStarts(2 * CT, c);
    check(c == 2, "R10 bus reset resumes", c, 2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule